// File: doc/BRIEF.md
# Lane Parity Guard for a 64-bit Data Path

This block protects a wide data transfer with one even-parity bit per 16-bit lane. On the sending side it produces the lane parity bits for outgoing read data. A small configuration register holds a per-lane injection mask. The mask is XORed onto the generated parity so that software can deliberately corrupt chosen lanes and confirm that the far end detects the error.

On the receiving side the block recomputes lane parity for each valid transfer and compares it with the parity bits that arrive with the data. Checking is off after reset and is turned on by an enable bit in the same configuration register. When checking is on, a failing transfer raises a one-cycle error pulse. It also sets sticky per-lane status bits, which software clears by writing ones to them.

Top module: `lane_parity_guard`

## Requirements
- R1: While reset is asserted and right after it, the mask is 0, checking is disabled, `err_lanes` is 0 and `err_pulse` is 0.
- R2: With a zero mask, `tx_par[i]` is the XOR of bits `16*i+15 .. 16*i` of `tx_data`, which is even parity for lane i.
- R3: A write with `cfg_we` high loads `cfg_wdata[3:0]` as the mask. From the next cycle on, `tx_par` equals the lane parity XOR the mask for every transfer, until the mask is rewritten.
- R4: The same write loads `cfg_wdata[4]` as the check enable. `cfg_rdata` returns `{enable, mask}` with the enable in bit 4.
- R5: When checking is enabled and `rx_valid` is high, any lane where `rx_par[i]` differs from the recomputed parity causes two things in the next cycle: `err_pulse` is high, and those lanes are set in `err_lanes`.
- R6: When checking is disabled, a parity mismatch on a valid transfer neither raises `err_pulse` nor sets any bit of `err_lanes`.
- R7: When `rx_valid` is low, `rx_data` and `rx_par` have no effect on `err_pulse` or `err_lanes`.
- R8: `err_lanes` bits are sticky. A bit clears in the cycle after a write with `clr_we` high and a one in the matching bit of `clr_lanes`. A new error on the same lane in that same cycle wins over the clear.
- R9: A valid transfer with correct parity on every lane does not raise `err_pulse`, even when checking is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Bits 3:0 are the mask, bit 4 is the check enable |
| cfg_rdata | output | 5 | Current configuration |
| tx_data | input | 64 | Outgoing read data |
| tx_par | output | 4 | Lane parity of `tx_data` XOR the mask |
| rx_valid | input | 1 | Received transfer valid |
| rx_data | input | 64 | Received data |
| rx_par | input | 4 | Received lane parity |
| clr_we | input | 1 | Status clear strobe |
| clr_lanes | input | 4 | Write-one-to-clear lane mask |
| err_pulse | output | 1 | One-cycle error indication |
| err_lanes | output | 4 | Sticky per-lane error status |

## Verification
The assertions check four things on every cycle:
- the reset state;
- that a pulse can only follow an enabled check;
- that a pulse is always backed by status;
- that status bits never drop without a clear.

The exact parity values remain for the bench's scenarios. These include the masked outgoing parity after each mask write, the precise lanes reported, the clear-versus-set race, and the silence of disabled or invalid transfers. The bench compares all of them against a behavioural model every cycle.

// File: rtl/lane_parity_guard.sv
module lane_parity_guard #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 16,
  localparam int LANES = DATA_W / LANE_W,
  localparam int CFG_W = LANES + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic [DATA_W-1:0] tx_data,
  output logic [LANES-1:0]  tx_par,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [LANES-1:0]  rx_par,
  input  logic              clr_we,
  input  logic [LANES-1:0]  clr_lanes,
  output logic              err_pulse,
  output logic [LANES-1:0]  err_lanes
);

  logic [LANES-1:0] inj_mask;
  logic             chk_en;
  logic [LANES-1:0] tx_calc, rx_calc, bad;
  logic             hit;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign tx_calc[i] = ^tx_data[i*LANE_W +: LANE_W];
    assign rx_calc[i] = ^rx_data[i*LANE_W +: LANE_W];
  end

  assign tx_par    = tx_calc ^ inj_mask;
  assign bad       = rx_calc ^ rx_par;
  assign hit       = rx_valid & chk_en & (|bad);
  assign cfg_rdata = {chk_en, inj_mask};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inj_mask  <= '0;
      chk_en    <= 1'b0;
      err_pulse <= 1'b0;
      err_lanes <= '0;
    end else begin
      err_pulse <= hit;
      err_lanes <= (err_lanes & ~(clr_we ? clr_lanes : '0)) | (hit ? bad : '0);
      if (cfg_we) begin
        inj_mask <= cfg_wdata[LANES-1:0];
        chk_en   <= cfg_wdata[LANES];
      end
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (err_lanes == '0 && !err_pulse && cfg_rdata == '0));

  // R6
  pulse_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_en |=> !err_pulse);

  // R5
  pulse_has_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (err_lanes != '0));

  // R8
  sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((err_lanes & $past(err_lanes)) == $past(err_lanes)));

endmodule

// File: tb/lane_parity_guard_bench.sv
module lane_parity_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_wdata = '0;
  logic [4:0]  cfg_rdata;
  logic [63:0] tx_data = '0;
  logic [3:0]  tx_par;
  logic        rx_valid = 1'b0;
  logic [63:0] rx_data = '0;
  logic [3:0]  rx_par = '0;
  logic        clr_we = 1'b0;
  logic [3:0]  clr_lanes = '0;
  logic        err_pulse;
  logic [3:0]  err_lanes;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lane_parity_guard u_lane_parity_guard (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .tx_data(tx_data), .tx_par(tx_par),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_par(rx_par),
    .clr_we(clr_we), .clr_lanes(clr_lanes), .err_pulse(err_pulse),
    .err_lanes(err_lanes));

  function automatic logic [3:0] even_par(input logic [63:0] d);
    logic [3:0] p;
    for (int l = 0; l < 4; l++) begin
      int ones = 0;
      for (int b = 0; b < 16; b++) if (d[l*16+b]) ones++;
      p[l] = (ones % 2 == 1);
    end
    return p;
  endfunction

  logic [3:0] m_mask = '0, m_status = '0;
  logic       m_en = 0, m_pulse = 0, m_in_reset = 1;
  string      ev_tag = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mask = '0; m_en = 0; m_status = '0; m_pulse = 0; m_in_reset = 1; ev_tag = "R1";
    end else begin
      logic [3:0] mism;
      logic       np;
      mism = even_par(rx_data) ^ rx_par;
      np = rx_valid && m_en && (mism != 0);
      if (!rx_valid) ev_tag = "R7";
      else if (!m_en) ev_tag = "R6";
      else if (mism == 0) ev_tag = "R9";
      else ev_tag = "R5";
      m_status = (m_status & ~(clr_we ? clr_lanes : 4'h0)) | (np ? mism : 4'h0);
      m_pulse = np;
      if (cfg_we) begin m_mask = cfg_wdata[3:0]; m_en = cfg_wdata[4]; end
      m_in_reset = 0;
    end
  end

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      if (done) break;
      if (m_in_reset) begin
        check("R1", "status", 64'(err_lanes), 64'(m_status));
        check("R1", "pulse", 64'(err_pulse), 64'(m_pulse));
        check("R1", "cfg", 64'(cfg_rdata), 64'({m_en, m_mask}));
      end else begin
        check(m_mask == 0 ? "R2" : "R3", "tx_par", 64'(tx_par), 64'(even_par(tx_data) ^ m_mask));
        check("R4", "cfg", 64'(cfg_rdata), 64'({m_en, m_mask}));
        check(ev_tag, "pulse", 64'(err_pulse), 64'(m_pulse));
        check("R8", "status", 64'(err_lanes), 64'(m_status));
      end
    end
  end

  task automatic cyc(input bit v, input logic [63:0] d, input logic [3:0] flip);
    @(negedge clk);
    cfg_we = 0; clr_we = 0;
    rx_valid = v; rx_data = d; rx_par = even_par(d) ^ flip;
    tx_data = {$urandom, $urandom};
  endtask

  task automatic wcfg(input logic [4:0] v);
    @(negedge clk);
    clr_we = 0; rx_valid = 0; cfg_we = 1; cfg_wdata = v;
    tx_data = {$urandom, $urandom};
  endtask

  task automatic wclr(input logic [3:0] c, input bit v, input logic [3:0] flip);
    logic [63:0] d;
    d = {$urandom, $urandom};
    @(negedge clk);
    cfg_we = 0; clr_we = 1; clr_lanes = c;
    rx_valid = v; rx_data = d; rx_par = even_par(d) ^ flip;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    // R2: zero mask traffic; R6: checking still disabled
    for (int i = 0; i < 20; i++) cyc(1, {$urandom, $urandom}, 4'($urandom));
    // R3 with checking disabled
    wcfg(5'h0A);
    for (int i = 0; i < 10; i++) cyc(1, {$urandom, $urandom}, 4'($urandom));
    // R4, R9, R5
    wcfg(5'h10);
    for (int i = 0; i < 10; i++) cyc(1, {$urandom, $urandom}, 4'h0);
    cyc(1, 64'h0001_0000_0000_0000, 4'h0);
    cyc(1, {$urandom, $urandom}, 4'h2);
    cyc(1, {$urandom, $urandom}, 4'h8);
    cyc(1, 64'hFFFF_FFFF_FFFF_FFFF, 4'h1);
    // R7
    for (int i = 0; i < 10; i++) cyc(0, {$urandom, $urandom}, 4'hF);
    // R8: partial clear, then clear racing a new error
    wclr(4'h3, 0, 4'h0);
    cyc(0, '0, 4'h0);
    wclr(4'hF, 1, 4'h4);
    cyc(0, '0, 4'h0);
    wclr(4'hF, 0, 4'h0);
    // mixed traffic with masks
    for (int k = 0; k < 16; k++) begin
      wcfg({1'b1, 4'(k)});
      for (int i = 0; i < 20; i++) cyc($urandom % 4 != 0, {$urandom, $urandom}, 4'($urandom));
      if (k % 3 == 0) wclr(4'($urandom), 1, 4'($urandom));
    end
    wcfg(5'h05);
    for (int i = 0; i < 20; i++) cyc(1, {$urandom, $urandom}, 4'($urandom));
    // reset again mid-run
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 5; i++) cyc(1, {$urandom, $urandom}, 4'hF);
    @(negedge clk);
    done = 1;
    #1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog run did not end actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule